// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block sits between a synchronous host and a 64K-word by 16-bit asynchronous static RAM. Active-low strobes control the RAM: chip select, output gate, write strobe, and one select for each byte lane. The host presents a request with a direction, an address, write data and a two-bit lane mask. The controller then runs a fixed strobe sequence on the RAM pins and answers with a one-clock ready pulse. A read also returns data on that pulse.

The number of clocks in each phase comes from the clock period and the RAM's access, write-pulse and float times, all given in picoseconds as parameters. Lower and upper byte lanes are strobed independently, and lanes the mask leaves out are never touched. The RAM's data pins are split into an outgoing bus, an incoming bus and a drive enable, so a pad ring or a bench model can join them.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, chip select, output gate, write strobe and both lane selects are high. Bus drive is off, ready is low and read data is zero.
- R2: During a read, chip select and output gate are low and the write strobe is high. While chip select stays low across consecutive clocks, the address pins do not change.
- R3: Mask bit 0 enables the lower lane select and data bits 7:0. Mask bit 1 enables the upper lane select and bits 15:8. A lane whose bit is 0 keeps its select high and returns zero in read data. With a mask of 00, the request still completes with ready and changes no memory content.
- R4: Read data is sampled after RD_CYC clocks of asserted read strobes (5 at the default parameters), and ready follows on the next clock. A request presented in idle therefore sees ready on the RD_CYC+1-th clock edge.
- R5: In a write, chip select and the enabled lane selects go low one clock before the write strobe falls. The write strobe stays low for exactly WP_CYC clocks (4 at the defaults). Chip select and the lane selects stay low for one clock after it rises. The output gate stays high throughout.
- R6: A write stores the host data into the enabled lanes at the given address and leaves the other lane's contents unchanged.
- R7: Bus drive is on only while the write strobe is low and in the single clock after it rises. It is never on while the output gate is low.
- R8: After a read, chip select and output gate stay high for at least GAP_CYC clocks (2 at the defaults). Bus drive never turns on until the output gate has been high for more than GAP_CYC clocks.
- R9: Ready is high for exactly one clock per request. For a write it arrives on the WP_CYC+3-th clock edge after the request is presented in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request; held with its fields until ready is seen |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane enables, bit 0 lower, bit 1 upper |
| host_ready | output | 1 | One-clock completion pulse |
| host_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | 16 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_in | input | 16 | Data from the RAM |
| mem_dq_oe | output | 1 | Enables the controller's drive of the data pins |

## Verification
Every request is presented on a falling clock edge. At the default parameters, ready for a read is due at the falling edge after the sixth rising edge, and for a write after the seventh. The bench counts falling edges from the request to ready and compares the count with those figures; it reads the returned data in the same half-cycle. Strobe order, write-strobe width, address hold, bus ownership and the read-to-write gap are checked on every falling edge. These checks use running counters of how many clocks each pin has held its level. Write results are checked by reading the address back through the host side.

// File: rtl/sram_lane_pkg.sv
// Shared types and helpers for the static-RAM lane controller.
// Assumes all times are integer picoseconds and the clock period is non-zero.
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no cycle on the pins
        ST_RD,     // read strobes asserted, waiting out access time
        ST_GAP,    // post-read float gap, all strobes high
        ST_WSET,   // chip and lane selects low, write strobe still high
        ST_WPUL,   // write strobe low, data driven
        ST_WHLD    // write strobe high again, data and selects held
    } seq_state_t;

    // Whole clocks covering a time, never less than one.
    function automatic int cyc_of(input int t_ps, input int clk_ps);
        int n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/sram_lane_seq.sv
// Strobe sequencer: walks the read and write phases and registers every
// RAM control pin from the next state, so the pins change only on clock edges.
// Assumes the host holds its request until ready and that RD_CYC, WP_CYC and
// GAP_CYC are at least 1.
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int RD_CYC  = 5,
    parameter int WP_CYC  = 4,
    parameter int GAP_CYC = 2,
    parameter int CW      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_wr,
    output logic accept,
    output logic capture,
    output logic ready,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_oe
);

    seq_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          done;

    // Next-state and phase counter decisions.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        capture = 1'b0;
        done    = 1'b0;
        case (st_q)
            ST_IDLE: if (req && !ready) begin
                accept = 1'b1;
                cnt_d  = CW'(RD_CYC - 1);
                st_d   = req_wr ? ST_WSET : ST_RD;
            end
            ST_RD: if (cnt_q == '0) begin
                capture = 1'b1;
                done    = 1'b1;
                cnt_d   = CW'(GAP_CYC - 1);
                st_d    = ST_GAP;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
            ST_GAP: if (cnt_q == '0) st_d = ST_IDLE;
                    else cnt_d = cnt_q - 1'b1;
            ST_WSET: begin
                cnt_d = CW'(WP_CYC - 1);
                st_d  = ST_WPUL;
            end
            ST_WPUL: if (cnt_q == '0) st_d = ST_WHLD;
                     else cnt_d = cnt_q - 1'b1;
            ST_WHLD: begin
                done = 1'b1;
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, counter, ready pulse and pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            ready <= 1'b0;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ready <= done;
            ce_n  <= !(st_d inside {ST_RD, ST_WSET, ST_WPUL, ST_WHLD});
            oe_n  <= (st_d != ST_RD);
            we_n  <= (st_d != ST_WPUL);
            dq_oe <= (st_d inside {ST_WPUL, ST_WHLD});
        end
    end

    // Checker counters: length of the current write-strobe low run and
    // clocks since the output gate was last low (both saturating).
    logic [CW:0] we_run_q, oe_hi_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run_q <= '0;
            oe_hi_q  <= '1;
        end else begin
            we_run_q <= !we_n ? ((we_run_q == '1) ? we_run_q : we_run_q + 1'b1) : '0;
            oe_hi_q  <= !oe_n ? '0 : ((oe_hi_q == '1) ? oe_hi_q : oe_hi_q + 1'b1);
        end
    end

    assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!ce_n && we_n));
    assert_we_opens_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ($past(ce_n) == 1'b0));
    assert_we_closes_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> !ce_n);
    assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run_q == (CW+1)'(WP_CYC)));
    assert_no_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && (!we_n || !$past(we_n))));
    assert_float_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (oe_hi_q > (CW+1)'(GAP_CYC)));
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

endmodule

// File: rtl/sram_lane_dp.sv
// Datapath: latches address, write data and lane mask when a request is
// taken, and samples read data per lane with disabled lanes forced to zero.
// Assumes DW splits evenly into LANES lanes.
module sram_lane_dp #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             capture,
    input  logic [AW-1:0]    in_addr,
    input  logic [DW-1:0]    in_wdata,
    input  logic [LANES-1:0] in_mask,
    input  logic [DW-1:0]    dq_in,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    wdata_q,
    output logic [LANES-1:0] mask_q,
    output logic [DW-1:0]    rdata_q
);

    localparam int LW = DW / LANES;

    // Request field latch, loaded only when the sequencer takes a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
            mask_q  <= in_mask;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane read sample, zero for a disabled lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata_q[g*LW +: LW] <= '0;
            else if (capture)
                rdata_q[g*LW +: LW] <= mask_q[g] ? dq_in[g*LW +: LW] : '0;
        end

        assert_off_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (capture && !mask_q[g]) |=> (rdata_q[g*LW +: LW] == '0));
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
// Top of the static-RAM byte-lane controller. Turns picosecond timing
// parameters into clock counts and joins the sequencer and datapath to
// the host and RAM pins. Assumes a 16-bit word split into two byte lanes.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int CLK_PS  = 4000,
    parameter int T_RD_PS = 20000,
    parameter int T_WP_PS = 15000,
    parameter int T_HZ_PS = 8000,
    parameter int AW      = 16,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [1:0]    host_mask,
    output logic          host_ready,
    output logic [DW-1:0] host_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_dq_oe
);

    localparam int LANES   = 2;
    localparam int RD_CYC  = cyc_of(T_RD_PS, CLK_PS);
    localparam int WP_CYC  = cyc_of(T_WP_PS, CLK_PS);
    localparam int GAP_CYC = cyc_of(T_HZ_PS, CLK_PS);
    localparam int MAXC    = (RD_CYC > WP_CYC) ? ((RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC)
                                               : ((WP_CYC > GAP_CYC) ? WP_CYC : GAP_CYC);
    localparam int CW      = $clog2(MAXC + 2);

    logic             accept, capture;
    logic [LANES-1:0] mask_q;

    sram_lane_seq #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .GAP_CYC(GAP_CYC),
        .CW     (CW)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (host_req),
        .req_wr (host_wr),
        .accept (accept),
        .capture(capture),
        .ready  (host_ready),
        .ce_n   (mem_ce_n),
        .oe_n   (mem_oe_n),
        .we_n   (mem_we_n),
        .dq_oe  (mem_dq_oe)
    );

    sram_lane_dp #(
        .AW   (AW),
        .DW   (DW),
        .LANES(LANES)
    ) dp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .capture (capture),
        .in_addr (host_addr),
        .in_wdata(host_wdata),
        .in_mask (host_mask),
        .dq_in   (mem_dq_in),
        .addr_q  (mem_addr),
        .wdata_q (mem_dq_out),
        .mask_q  (mask_q),
        .rdata_q (host_rdata)
    );

    // Lane selects follow chip select, gated by the latched mask.
    assign mem_lb_n = mem_ce_n | !mask_q[0];
    assign mem_ub_n = mem_ce_n | !mask_q[1];

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    assert_we_needs_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n) |-> (mask_q != '0 || (mem_lb_n && mem_ub_n)));

endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;

    localparam int CLK_PS = 4000;
    localparam int RD_E   = (20000 + CLK_PS - 1) / CLK_PS;  // 5
    localparam int WP_E   = (15000 + CLK_PS - 1) / CLK_PS;  // 4
    localparam int GAP_E  = (8000  + CLK_PS - 1) / CLK_PS;  // 2

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [15:0] host_addr = '0, host_wdata = '0;
    logic [1:0]  host_mask = '0;
    logic        host_ready;
    logic [15:0] host_rdata, mem_addr, mem_dq_out, mem_dq_in;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;

    int checks = 0, errors = 0;
    logic [1:0] cur_mask = 2'b00;

    always #2 clk = ~clk;

    sram_lane_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
        .host_ready(host_ready), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // Small RAM model, indexed by the low address byte; filler on idle lanes.
    logic [15:0] ram [0:255];
    initial for (int i = 0; i < 256; i++) ram[i] = {8'(i), ~8'(i)};
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n)
        ? {mem_ub_n ? 8'hA5 : ram[mem_addr[7:0]][15:8],
           mem_lb_n ? 8'h5A : ram[mem_addr[7:0]][7:0]}
        : 16'hC3C3;
    always @(posedge clk)
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) ram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) ram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pin-level monitors on every falling edge.
    logic        p_we_n = 1'b1, p_ce_n = 1'b1, p_oe_n = 1'b1, p_oe = 1'b0, p_rdy = 1'b0;
    logic [15:0] p_addr = '0;
    int          we_low = 0, oe_hi = 100;
    always @(negedge clk) if (rst_n) begin
        if (!mem_oe_n) check(!mem_ce_n && mem_we_n, "R2 read strobes", {mem_ce_n, mem_we_n}, 2'b01);
        if (!mem_ce_n && !p_ce_n) check(mem_addr == p_addr, "R2 address hold", mem_addr, p_addr);
        if (!mem_ce_n) check(mem_lb_n == !cur_mask[0] && mem_ub_n == !cur_mask[1],
                             "R3 lane selects", {mem_ub_n, mem_lb_n}, ~cur_mask);
        if (!mem_we_n) begin
            we_low++;
            check(mem_oe_n, "R5 gate high in write", mem_oe_n, 1);
            if (p_we_n) check(!p_ce_n, "R5 select before strobe", p_ce_n, 0);
        end else if (!p_we_n) begin
            check(we_low == WP_E, "R5 strobe width", we_low, WP_E);
            check(!mem_ce_n, "R5 select after strobe", mem_ce_n, 0);
            we_low = 0;
        end
        if (mem_dq_oe) check(mem_oe_n && (!mem_we_n || !p_we_n), "R7 drive window",
                             {mem_oe_n, mem_we_n, p_we_n}, 3'b100);
        if (!mem_oe_n) oe_hi = 0; else if (oe_hi < 100) oe_hi++;
        if (mem_dq_oe && !p_oe) check(oe_hi >= GAP_E + 2, "R8 float gap", oe_hi, GAP_E + 2);
        if (host_ready && p_rdy) check(0, "R9 ready pulse", 2, 1);
        p_we_n = mem_we_n; p_ce_n = mem_ce_n; p_oe = mem_dq_oe; p_rdy = host_ready; p_addr = mem_addr;
    end

    task automatic run_op(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                          input logic [1:0] m, output logic [15:0] rd, output int lat);
        host_wr = wr; host_addr = a; host_wdata = wd; host_mask = m; cur_mask = m;
        host_req = 1'b1; lat = 0;
        do begin @(negedge clk); lat++; end while (!host_ready && lat < 60);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [1:0]  mask;
        logic [15:0] exp;
    } vec_t;
    localparam vec_t VECS [13] = '{
        '{1'b1, 16'h000A, 16'h1234, 2'b11, 16'h0000},
        '{1'b0, 16'h000A, 16'h0000, 2'b11, 16'h1234},
        '{1'b1, 16'h000A, 16'hABCD, 2'b01, 16'h0000},
        '{1'b0, 16'h000A, 16'h0000, 2'b11, 16'h12CD},
        '{1'b1, 16'h000A, 16'h5566, 2'b10, 16'h0000},
        '{1'b0, 16'h000A, 16'h0000, 2'b11, 16'h55CD},
        '{1'b0, 16'h000A, 16'h0000, 2'b01, 16'h00CD},
        '{1'b0, 16'h000A, 16'h0000, 2'b10, 16'h5500},
        '{1'b1, 16'h0014, 16'hFFFF, 2'b00, 16'h0000},
        '{1'b0, 16'h0014, 16'h0000, 2'b11, 16'h14EB},
        '{1'b0, 16'h0014, 16'h0000, 2'b00, 16'h0000},
        '{1'b1, 16'hFFFF, 16'hBEEF, 2'b11, 16'h0000},
        '{1'b0, 16'hFFFF, 16'h0000, 2'b11, 16'hBEEF}
    };

    initial begin
        #(4 * 150000);
        check(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int          lat;
        repeat (4) @(negedge clk);
        // R1: reset state at the pins.
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 5'b11111,
              "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'b11111);
        check(!mem_dq_oe && !host_ready && host_rdata == 16'h0, "R1 drive ready data",
              {mem_dq_oe, host_ready, host_rdata}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: R3 R6 results read back through the host port.
        for (int i = 0; i < 13; i++) begin
            run_op(VECS[i].wr, VECS[i].addr, VECS[i].wd, VECS[i].mask, rd, lat);
            if (!VECS[i].wr) check(rd == VECS[i].exp, "R6/R3 read data", rd, VECS[i].exp);
            repeat (3) @(negedge clk);
        end

        // R4: read latency from presentation to ready.
        run_op(1'b0, 16'h0030, 16'h0, 2'b11, rd, lat);
        check(lat == RD_E + 1, "R4 read latency", lat, RD_E + 1);
        check(rd == 16'h30CF, "R4 read data", rd, 16'h30CF);
        repeat (3) @(negedge clk);

        // R9: write latency from presentation to ready.
        run_op(1'b1, 16'h0031, 16'h7788, 2'b11, rd, lat);
        check(lat == WP_E + 3, "R9 write latency", lat, WP_E + 3);
        @(negedge clk);
        check(!host_ready, "R9 ready one clock", host_ready, 0);
        repeat (2) @(negedge clk);

        // R8: read then write back to back; monitors check the float gap.
        run_op(1'b0, 16'h0031, 16'h0, 2'b11, rd, lat);
        check(rd == 16'h7788, "R6 readback", rd, 16'h7788);
        run_op(1'b1, 16'h0032, 16'h2468, 2'b01, rd, lat);
        check(lat > WP_E + 3, "R8 write waits for gap", lat, WP_E + 4);
        run_op(1'b0, 16'h0032, 16'h0, 2'b11, rd, lat);
        check(rd == 16'h3268, "R6 lower lane only", rd, 16'h3268);
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule